// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Channel

This block is one timer channel that builds a pulse-width-modulated output from a free-running counter value. The counter is generated elsewhere and shared between channels. Two active compare values place the two edges of each pulse. The leading-edge value (A) drives the output to one level, and the trailing-edge value (B) drives it to the other. A polarity input decides which level is which.

Software never writes the active compare values directly. It writes two shadow values, and these are copied into the active pair only when the counter wraps. A new period therefore always starts with a consistent pair of edges. A per-channel update-disable input can hold the copy back, so that several channels can be changed and then released together.

A sticky flag marks compare events. A mode code selects whether the flag is raised on the trailing match only or on both matches. Two force strobes let software put the output at either match level without raising the flag. Fixed precedence rules settle colliding matches.

Top module: `pwm_buf_chan`

## Requirements
- R1: A counter value equal to active A makes the output go to the A level one clock later. A value equal to active B makes it go to the B level one clock later. With `pol_i` = 0, the A level is 0 and the B level is 1. Between matches the output holds its value.
- R2: With `pol_i` = 1, both levels are swapped: the A level is 1 and the B level is 0.
- R3: A wrap is a clock on which `cnt_i` is below its value on the previous clock. On a wrap clock, the shadow values are copied into active A and B. The copied values are already used for the compare on that same wrap clock. A shadow write made during one period takes effect from the next wrap.
- R4: While `upd_dis_i` is 1 on a wrap clock, no copy happens. The old active values stay in use, and the shadow values are kept for a later wrap.
- R5: When `mode_i` is any code other than 7'b1100010 (in particular 7'b1100000), only a B match sets `flag_o`. A matches leave it unchanged.
- R6: When `mode_i` is 7'b1100010, both an effective A match and a B match set `flag_o`.
- R7: `flag_o` stays set until a one-clock pulse on `flag_clr_i`. If a set and a clear fall on the same clock, the flag stays set. Output edges continue while the flag is set.
- R8: When A and B match on the same clock, the output takes the B level.
- R9: Once B has matched within a counter period, later A matches in that period are ignored. They change neither the output nor the flag.
- R10: An A match at count 0 on the wrap clock changes the output, even though a B match occurred late in the previous period.
- R11: `force_a_i` drives the output to the A level and `force_b_i` drives it to the B level. Either takes effect one clock later and overrides any match on that clock. If both are asserted, `force_b_i` wins. Neither strobe sets the flag.
- R12: Reset (`rst_n` low) clears the output and the flag. It also sets the active and shadow A and B values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Shared free-running counter value |
| mode_i | input | 7 | Mode code: 7'b1100000 flags on B only, 7'b1100010 flags on both matches |
| pol_i | input | 1 | Polarity: 0 means the A match drives low and the B match drives high |
| upd_dis_i | input | 1 | Blocks the shadow-to-active copy at the wrap |
| a_wr_i | input | 1 | Write strobe for shadow A |
| a_val_i | input | CW | Data for shadow A |
| b_wr_i | input | 1 | Write strobe for shadow B |
| b_val_i | input | CW | Data for shadow B |
| force_a_i | input | 1 | Drive the output to the A level |
| force_b_i | input | 1 | Drive the output to the B level |
| flag_clr_i | input | 1 | Write-1-to-clear pulse for the flag |
| pwm_o | output | 1 | PWM output |
| flag_o | output | 1 | Sticky match flag |

## Verification
The bound checker checks the following on every cycle:
- the level that follows a B match or an effective A match;
- that a masked A match leaves the output steady;
- that the active values take the shadow contents at an enabled wrap and hold while update-disable is set;
- that the flag stays sticky and only rises on a match.

Some behaviours only the bench's directed scenarios can show, because they depend on a chosen counter sequence:
- the one-period delay before a shadow write takes effect;
- an A match at zero winning just after a late B match;
- a set colliding with a clear;
- a force colliding with a match;
- the exact flag behaviour under each mode code.

// File: rtl/pwm_buf_chan.sv
module pwm_buf_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [6:0]    mode_i,
  input  logic          pol_i,
  input  logic          upd_dis_i,
  input  logic          a_wr_i,
  input  logic [CW-1:0] a_val_i,
  input  logic          b_wr_i,
  input  logic [CW-1:0] b_val_i,
  input  logic          force_a_i,
  input  logic          force_b_i,
  input  logic          flag_clr_i,
  output logic          pwm_o,
  output logic          flag_o
);

  localparam logic [6:0] MODE_BOTH = 7'b1100010;

  logic [CW-1:0] a_act, b_act, a_shd, b_shd, cnt_q;
  logic [CW-1:0] a_eff, b_eff;
  logic          b_seen, wrap, reload, a_hit, b_hit, a_live, flag_set;

  assign wrap     = cnt_i < cnt_q;
  assign reload   = wrap & ~upd_dis_i;
  assign a_eff    = reload ? a_shd : a_act;
  assign b_eff    = reload ? b_shd : b_act;
  assign a_hit    = cnt_i == a_eff;
  assign b_hit    = cnt_i == b_eff;
  assign a_live   = a_hit & (wrap | ~b_seen);
  assign flag_set = b_hit | (a_live & (mode_i == MODE_BOTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      a_act  <= '0;
      b_act  <= '0;
      a_shd  <= '0;
      b_shd  <= '0;
      b_seen <= 1'b0;
      pwm_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      cnt_q <= cnt_i;
      if (a_wr_i) a_shd <= a_val_i;
      if (b_wr_i) b_shd <= b_val_i;
      if (reload) begin
        a_act <= a_shd;
        b_act <= b_shd;
      end
      b_seen <= wrap ? b_hit : (b_seen | b_hit);
      if (force_b_i)      pwm_o <= ~pol_i;
      else if (force_a_i) pwm_o <= pol_i;
      else if (b_hit)     pwm_o <= ~pol_i;
      else if (a_live)    pwm_o <= pol_i;
      flag_o <= flag_set | (flag_o & ~flag_clr_i);
    end
  end

endmodule

module pwm_buf_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pol_i,
  input logic          upd_dis_i,
  input logic          force_a_i,
  input logic          force_b_i,
  input logic          flag_clr_i,
  input logic          pwm_o,
  input logic          flag_o,
  input logic          wrap,
  input logic          a_hit,
  input logic          a_live,
  input logic          b_hit,
  input logic          b_seen,
  input logic [CW-1:0] a_act,
  input logic [CW-1:0] b_act,
  input logic [CW-1:0] a_shd,
  input logic [CW-1:0] b_shd
);

  // R1, R2, R8: a B match drives the B level unless a force overrides it
  assert_b_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit && !force_a_i && !force_b_i) |=> (pwm_o == !$past(pol_i)));

  // R1, R2: an effective A match without B drives the A level
  assert_a_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_live && !b_hit && !force_a_i && !force_b_i) |=> (pwm_o == $past(pol_i)));

  // R9: an A match after a B match in the same period leaves the output steady
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_seen && !wrap && a_hit && !b_hit && !force_a_i && !force_b_i) |=> $stable(pwm_o));

  // R3: an enabled wrap copies the shadow values into the active ones
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !upd_dis_i) |=> (a_act == $past(a_shd) && b_act == $past(b_shd)));

  // R4: while update-disable is set, the active values do not change
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis_i |=> ($stable(a_act) && $stable(b_act)));

  // R7: the flag is sticky without a clear
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R11: the flag rises only on a match, never on a force alone
  assert_no_force_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !b_hit && !a_live) |=> !flag_o);

endmodule

bind pwm_buf_chan pwm_buf_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_i(pol_i), .upd_dis_i(upd_dis_i),
  .force_a_i(force_a_i), .force_b_i(force_b_i), .flag_clr_i(flag_clr_i),
  .pwm_o(pwm_o), .flag_o(flag_o), .wrap(wrap), .a_hit(a_hit),
  .a_live(a_live), .b_hit(b_hit), .b_seen(b_seen), .a_act(a_act),
  .b_act(b_act), .a_shd(a_shd), .b_shd(b_shd)
);

// File: tb/pwm_buf_chan_tb.sv
module pwm_buf_chan_tb;
  localparam int CW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 40;
  localparam logic [6:0] M_B    = 7'b1100000;
  localparam logic [6:0] M_BOTH = 7'b1100010;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_i = '0, a_val_i = '0, b_val_i = '0;
  logic [6:0] mode_i = M_B;
  logic pol_i = 0, upd_dis_i = 0, a_wr_i = 0, b_wr_i = 0;
  logic force_a_i = 0, force_b_i = 0, flag_clr_i = 0;
  logic pwm_o, flag_o;

  int checks = 0, failures = 0, cycles = 0;
  int cur = 0;

  pwm_buf_chan #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .mode_i(mode_i), .pol_i(pol_i),
    .upd_dis_i(upd_dis_i), .a_wr_i(a_wr_i), .a_val_i(a_val_i), .b_wr_i(b_wr_i),
    .b_val_i(b_val_i), .force_a_i(force_a_i), .force_b_i(force_b_i),
    .flag_clr_i(flag_clr_i), .pwm_o(pwm_o), .flag_o(flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at count %0d: actual=%0b expected=%0b", req, cur, act, exp);
    end
  endtask

  // drives the next counter value with any strobes set by the caller, one clock
  task automatic adv();
    cur = (cur + 1) % PER;
    cnt_i = CW'(cur);
    @(posedge clk); #1;
    a_wr_i = 0; b_wr_i = 0; force_a_i = 0; force_b_i = 0; flag_clr_i = 0;
  endtask

  task automatic go_to(input int tgt);
    adv();
    while (cur != tgt) adv();
  endtask

  task automatic wr(input int a, input int b);
    a_val_i = CW'(a); b_val_i = CW'(b); a_wr_i = 1; b_wr_i = 1;
    adv();
  endtask

  task automatic clr();
    flag_clr_i = 1;
    adv();
  endtask

  task automatic t_reset();
    chk("R12 reset pwm", pwm_o, 1'b0);
    chk("R12 reset flag", flag_o, 1'b0);
  endtask

  task automatic t_basic();
    pol_i = 0; mode_i = M_B;
    wr(10, 20);
    go_to(0);
    go_to(20);
    chk("R1 B match level", pwm_o, 1'b1);
    chk("R5 flag on B", flag_o, 1'b1);
    go_to(0);
    clr();
    go_to(10);
    chk("R1 A match level", pwm_o, 1'b0);
    chk("R5 no flag on A", flag_o, 1'b0);
  endtask

  task automatic t_buffer();
    wr(5, 30);
    go_to(20);
    chk("R3 old B still active", pwm_o, 1'b1);
    go_to(0);
    go_to(5);
    chk("R3 new A after wrap", pwm_o, 1'b0);
    go_to(20);
    chk("R3 old B retired", pwm_o, 1'b0);
    go_to(30);
    chk("R3 new B after wrap", pwm_o, 1'b1);
  endtask

  task automatic t_upd();
    upd_dis_i = 1;
    wr(12, 25);
    go_to(0);
    go_to(5);
    chk("R4 blocked, old A used", pwm_o, 1'b0);
    go_to(25);
    chk("R4 blocked, new B unused", pwm_o, 1'b0);
    go_to(30);
    chk("R4 blocked, old B used", pwm_o, 1'b1);
    upd_dis_i = 0;
    go_to(0);
    go_to(5);
    chk("R4 released, old A gone", pwm_o, 1'b1);
    go_to(12);
    chk("R4 released, kept shadow A", pwm_o, 1'b0);
    go_to(25);
    chk("R4 released, kept shadow B", pwm_o, 1'b1);
  endtask

  task automatic t_pol();
    pol_i = 1;
    go_to(12);
    chk("R2 inverted A level", pwm_o, 1'b1);
    go_to(25);
    chk("R2 inverted B level", pwm_o, 1'b0);
    go_to(12);
    chk("R2 inverted A level again", pwm_o, 1'b1);
    pol_i = 0;
  endtask

  task automatic t_both();
    mode_i = M_BOTH;
    clr();
    chk("R6 flag cleared", flag_o, 1'b0);
    go_to(25);
    chk("R6 flag on B", flag_o, 1'b1);
    clr();
    chk("R7 clear pulse", flag_o, 1'b0);
    go_to(12);
    chk("R6 flag on A", flag_o, 1'b1);
    go_to(25);
    go_to(12);
    chk("R7 edges continue with flag set", pwm_o, 1'b0);
    go_to(24);
    flag_clr_i = 1;
    adv();
    chk("R7 set beats clear", flag_o, 1'b1);
    clr();
    chk("R7 clear after collision", flag_o, 1'b0);
  endtask

  task automatic t_same();
    wr(15, 15);
    go_to(0);
    force_a_i = 1;
    adv();
    chk("R11 force A level", pwm_o, 1'b0);
    go_to(15);
    chk("R8 B wins tie", pwm_o, 1'b1);
  endtask

  task automatic t_mask();
    mode_i = M_BOTH;
    wr(30, 10);
    go_to(0);
    force_a_i = 1;
    adv();
    go_to(10);
    chk("R9 B match", pwm_o, 1'b1);
    clr();
    go_to(30);
    chk("R9 masked A keeps output", pwm_o, 1'b1);
    chk("R9 masked A sets no flag", flag_o, 1'b0);
  endtask

  task automatic t_zero();
    wr(0, 39);
    go_to(0);
    chk("R10 A at zero on reload", pwm_o, 1'b0);
    go_to(39);
    chk("R10 late B match", pwm_o, 1'b1);
    go_to(0);
    chk("R10 A at zero beats prior B", pwm_o, 1'b0);
  endtask

  task automatic t_force();
    mode_i = M_B;
    clr();
    force_b_i = 1;
    adv();
    chk("R11 force B level", pwm_o, 1'b1);
    chk("R11 force B no flag", flag_o, 1'b0);
    force_a_i = 1;
    adv();
    chk("R11 force A level", pwm_o, 1'b0);
    chk("R11 force A no flag", flag_o, 1'b0);
    force_a_i = 1; force_b_i = 1;
    adv();
    chk("R11 force B wins", pwm_o, 1'b1);
    go_to(38);
    force_a_i = 1;
    adv();
    chk("R11 force overrides B match", pwm_o, 1'b0);
  endtask

  task automatic t_rerst();
    rst_n = 0; cur = 0; cnt_i = '0;
    @(posedge clk); #1;
    chk("R12 reset pwm mid-run", pwm_o, 1'b0);
    chk("R12 reset flag mid-run", flag_o, 1'b0);
    rst_n = 1;
    go_to(0);
    chk("R12 zeroed compares tie at 0", pwm_o, 1'b1);
    go_to(20);
    chk("R12 no old compare values", pwm_o, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    t_basic();
    t_buffer();
    t_upd();
    t_pol();
    t_both();
    t_same();
    t_mask();
    t_zero();
    t_force();
    t_rerst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule